// File: doc/BRIEF.md
# Drive status packet formatter

This block sits between a disc drive controller and the host that polls it. It owns a small byte-wide register window: two fader bytes, two control bytes, a ten-byte status packet and a ten-byte command packet. When the drive controller pulses an export strobe, the block packs the current status word together with minute, second and frame words and an extension byte into the status packet. Each 16-bit value is stored upper byte first. A 4-bit check value goes into the last packet byte. The block trims the control byte and, when enabled, raises an interrupt pulse.

The host writes command packets into the same window. When the controller pulses the command strobe, the block decodes the command code and returns a one-hot action pulse to the controller, which carries out the drive operation itself. For a table-of-contents request, the block also copies the request's sub-code into the low byte of its status word, so that the next export reports which query was answered. An out-of-range sub-code is replaced by an error marker.

Top module: `drv_stat_fmt`

## Requirements
- R1: After an export, register addresses 4 and 5 hold the status word's bits 15:8 and 7:0, addresses 6 and 7 hold the minute word (upper byte first), addresses 8 and 9 hold the second word, addresses 10 and 11 hold the frame word, and address 12 holds the extension byte.
- R2: After an export, address 13 holds zero in bits 7:4. Its bits 3:0 hold the bitwise inverse of bits 3:0 of the 8-bit wrap-around sum of addresses 4 to 12.
- R3: Reset (synchronous, active high) clears all 24 register bytes to 0x00 except address 13, which becomes 0x0F. It also clears the internal status word and drives irq_o and act_o low.
- R4: An export clears bits 7:2 of control byte address 3, keeps its bits 1:0, and leaves addresses 0 to 2 unchanged.
- R5: irq_o is high for exactly the one cycle after an export cycle in which irq_en_i was high. It is low in every other cycle.
- R6: A command with code 0x02 at address 14 is a table-of-contents request. If the sub-code at address 17 is 0x00 to 0x05, it is copied into bits 7:0 of the status word and bits 15:8 are kept. Any other sub-code writes 0x0F there and reports the status action instead of the request action. The result shows at addresses 4 and 5 after the next export.
- R7: In the cycle after cmd_go_i, act_o carries exactly one set bit, chosen by the code at address 14: 0x00 bit 0 (status), 0x01 bit 1 (stop), 0x02 bit 2 (table request), 0x03 bit 3 (read), 0x04 bit 4 (seek), 0x06 bit 5 (pause), 0x07 bit 6 (resume), 0x08 bit 7 (fast forward), 0x09 bit 8 (fast rewind), 0x0A bit 9 (recover), 0x0C bit 10 (close tray), 0x0D bit 11 (open tray), and any other value bit 12 (unknown). act_o is zero in other cycles.
- R8: All ten packet bytes, check byte included, take their new values in the same cycle, which is the cycle after export_i.
- R9: A host write to addresses 0 to 23 shows on the read port in the next cycle. The read port is combinational, addresses 24 to 31 read as 0x00, and writes to them change nothing.
- R10: When export_i and a host write fall in the same cycle, the export decides addresses 3 to 13. A host write to any other address still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we_i | input | 1 | Host byte write strobe |
| host_addr_i | input | 5 | Host write address |
| host_wdata_i | input | 8 | Host write data |
| rd_addr_i | input | 5 | Read port address |
| rd_data_o | output | 8 | Read port data (combinational) |
| stat_ld_i | input | 1 | Load the status word from stat_i |
| stat_i | input | 16 | Status word value |
| export_i | input | 1 | One-cycle export strobe |
| min_i | input | 16 | Minute word |
| sec_i | input | 16 | Second word |
| frm_i | input | 16 | Frame word |
| ext_i | input | 8 | Extension byte |
| irq_en_i | input | 1 | Interrupt enable sampled on export |
| irq_o | output | 1 | One-cycle interrupt request |
| cmd_go_i | input | 1 | One-cycle command decode strobe |
| act_o | output | 13 | One-hot action pulse |

## Verification
A wrong internal status word stays hidden until the next export. It then shows in two places one cycle later: at addresses 4 and 5, and as a check nibble at address 13 that disagrees with the bytes beside it. The bench therefore follows every table request with an export and a full read sweep. A wrong decode shows on act_o in the single cycle after the command strobe, as a missing, extra or misplaced bit. A byte cell holding a wrong value shows on the read port in the same cycle that the address is selected. For this reason the bench compares the read port, irq_o and act_o against its model on every clock.

// File: rtl/drv_stat_pkg.sv
package drv_stat_pkg;

    localparam int REG_BYTES   = 24;
    localparam int ADDR_W      = $clog2(REG_BYTES);
    localparam int CTRL_LO_IDX = 3;
    localparam int WIN_BASE    = 4;
    localparam int PKT_BYTES   = 10;
    localparam int CSUM_IDX    = WIN_BASE + PKT_BYTES - 1;
    localparam int CMD_IDX     = WIN_BASE + PKT_BYTES;
    localparam int SUB_IDX     = CMD_IDX + 3;

    localparam logic [7:0] CTRL_KEEP   = 8'h03;
    localparam logic [7:0] CMD_TOC     = 8'h02;
    localparam logic [7:0] TOC_SUB_MAX = 8'h05;
    localparam logic [7:0] TOC_BAD     = 8'h0F;

    typedef enum logic [3:0] {
        ACT_STATUS, ACT_STOP, ACT_TOC, ACT_READ, ACT_SEEK, ACT_PAUSE,
        ACT_RESUME, ACT_FFWD, ACT_FREW, ACT_RECOVER, ACT_CLOSE, ACT_OPEN,
        ACT_OTHER
    } act_e;

    localparam int NUM_ACT = int'(ACT_OTHER) + 1;

    typedef struct packed {
        logic [15:0] status;
        logic [15:0] minute;
        logic [15:0] second;
        logic [15:0] frame;
        logic [7:0]  ext;
    } pkt_t;

    function automatic logic [3:0] pkt_csum(input pkt_t p);
        logic [7:0] s;
        s = p.status[15:8] + p.status[7:0] + p.minute[15:8] + p.minute[7:0]
          + p.second[15:8] + p.second[7:0] + p.frame[15:8] + p.frame[7:0]
          + p.ext;
        return ~s[3:0];
    endfunction

    function automatic logic [7:0] pkt_lane(input pkt_t p, input int k);
        logic [7:0] b;
        case (k)
            0:       b = p.status[15:8];
            1:       b = p.status[7:0];
            2:       b = p.minute[15:8];
            3:       b = p.minute[7:0];
            4:       b = p.second[15:8];
            5:       b = p.second[7:0];
            6:       b = p.frame[15:8];
            7:       b = p.frame[7:0];
            8:       b = p.ext;
            default: b = {4'h0, pkt_csum(p)};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dsf_cmd_dec.sv
module dsf_cmd_dec
    import drv_stat_pkg::*;
(
    input  logic [7:0]         cmd_byte,
    input  logic [7:0]         sub_byte,
    output logic [NUM_ACT-1:0] act_oh,
    output logic               toc_we,
    output logic [7:0]         toc_low
);

    act_e sel;

    always_comb begin
        toc_we  = 1'b0;
        toc_low = TOC_BAD;
        unique case (cmd_byte)
            8'h00: sel = ACT_STATUS;
            8'h01: sel = ACT_STOP;
            CMD_TOC: begin
                toc_we = 1'b1;
                if (sub_byte <= TOC_SUB_MAX) begin
                    sel     = ACT_TOC;
                    toc_low = sub_byte;
                end else begin
                    sel     = ACT_STATUS;
                end
            end
            8'h03: sel = ACT_READ;
            8'h04: sel = ACT_SEEK;
            8'h06: sel = ACT_PAUSE;
            8'h07: sel = ACT_RESUME;
            8'h08: sel = ACT_FFWD;
            8'h09: sel = ACT_FREW;
            8'h0A: sel = ACT_RECOVER;
            8'h0C: sel = ACT_CLOSE;
            8'h0D: sel = ACT_OPEN;
            default: sel = ACT_OTHER;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NUM_ACT; i++) begin
            act_oh[i] = (sel == act_e'(i));
        end
    end

endmodule

// File: rtl/dsf_status_reg.sv
module dsf_status_reg (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld,
    input  logic [15:0] ld_val,
    input  logic        toc_we,
    input  logic [7:0]  toc_low,
    output logic [15:0] status_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            if (ld)     status_q       <= ld_val;
            if (toc_we) status_q[7:0]  <= toc_low;
        end
    end

endmodule

// File: rtl/dsf_window.sv
module dsf_window
    import drv_stat_pkg::*;
#(
    parameter int NB = REG_BYTES,
    parameter int AW = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                exp_en,
    input  pkt_t                pkt,
    output logic [NB-1:0][7:0]  bytes_q
);

    localparam logic [7:0] CSUM_RST = {4'h0, pkt_csum('0)};

    logic [7:0] cell_q [NB];

    for (genvar i = 0; i < NB; i++) begin : g_cell
        localparam bit IN_PKT = (i >= WIN_BASE) && (i < WIN_BASE + PKT_BYTES);
        localparam logic [7:0] RST_VAL = (i == CSUM_IDX) ? CSUM_RST : 8'h00;
        logic host_hit;
        assign host_hit = wr_en && (wr_addr == AW'(i));

        if (IN_PKT) begin : g_pkt
            localparam int K = i - WIN_BASE;
            always_ff @(posedge clk) begin
                if (rst)           cell_q[i] <= RST_VAL;
                else if (exp_en)   cell_q[i] <= pkt_lane(pkt, K);
                else if (host_hit) cell_q[i] <= wr_data;
            end
        end else if (i == CTRL_LO_IDX) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst)           cell_q[i] <= RST_VAL;
                else if (exp_en)   cell_q[i] <= cell_q[i] & CTRL_KEEP;
                else if (host_hit) cell_q[i] <= wr_data;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)           cell_q[i] <= RST_VAL;
                else if (host_hit) cell_q[i] <= wr_data;
            end
        end

        assign bytes_q[i] = cell_q[i];
    end

endmodule

// File: rtl/drv_stat_fmt.sv
module drv_stat_fmt
    import drv_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we_i,
    input  logic [ADDR_W-1:0]  host_addr_i,
    input  logic [7:0]         host_wdata_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [7:0]         rd_data_o,
    input  logic               stat_ld_i,
    input  logic [15:0]        stat_i,
    input  logic               export_i,
    input  logic [15:0]        min_i,
    input  logic [15:0]        sec_i,
    input  logic [15:0]        frm_i,
    input  logic [7:0]         ext_i,
    input  logic               irq_en_i,
    output logic               irq_o,
    input  logic               cmd_go_i,
    output logic [NUM_ACT-1:0] act_o
);

    logic [REG_BYTES-1:0][7:0] win_bytes;
    logic [15:0]               stat_word;
    logic [NUM_ACT-1:0]        dec_oh;
    logic                      dec_toc;
    logic [7:0]                dec_low;
    pkt_t                      pkt;

    assign pkt = '{status: stat_word, minute: min_i, second: sec_i,
                   frame: frm_i, ext: ext_i};

    dsf_cmd_dec u_dec (
        .cmd_byte (win_bytes[CMD_IDX]),
        .sub_byte (win_bytes[SUB_IDX]),
        .act_oh   (dec_oh),
        .toc_we   (dec_toc),
        .toc_low  (dec_low)
    );

    dsf_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .ld       (stat_ld_i),
        .ld_val   (stat_i),
        .toc_we   (cmd_go_i && dec_toc),
        .toc_low  (dec_low),
        .status_q (stat_word)
    );

    dsf_window u_win (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_we_i),
        .wr_addr (host_addr_i),
        .wr_data (host_wdata_i),
        .exp_en  (export_i),
        .pkt     (pkt),
        .bytes_q (win_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            act_o <= '0;
        end else begin
            irq_o <= export_i && irq_en_i;
            act_o <= cmd_go_i ? dec_oh : '0;
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < REG_BYTES; i++) begin
            if (rd_addr_i == ADDR_W'(i)) rd_data_o = win_bytes[i];
        end
    end

endmodule

// File: rtl/drv_stat_fmt_chk.sv
module drv_stat_fmt_chk
    import drv_stat_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      export_i,
    input logic                      irq_en_i,
    input logic                      irq_o,
    input logic                      cmd_go_i,
    input logic                      stat_ld_i,
    input logic [NUM_ACT-1:0]        act_o,
    input logic [15:0]               status_q,
    input logic [PKT_BYTES-1:0][7:0] pkt_win,
    input logic [7:0]                ctrl_b,
    input logic [7:0]                cmd_b
);

    logic [7:0] body_sum;
    always_comb begin
        body_sum = '0;
        for (int k = 0; k < PKT_BYTES - 1; k++) body_sum = body_sum + pkt_win[k];
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (status_q == 16'h0 && pkt_win[PKT_BYTES-1] == 8'h0F && !irq_o && act_o == '0)); // R3

    AST_CSUM_AFTER_EXPORT: assert property (@(posedge clk) disable iff (rst)
        export_i |=> (pkt_win[PKT_BYTES-1] == {4'h0, ~body_sum[3:0]})); // R2

    AST_CTRL_TRIMMED: assert property (@(posedge clk) disable iff (rst)
        export_i |=> (ctrl_b[7:2] == 6'h0)); // R4

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(export_i) && $past(irq_en_i))); // R5

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (export_i && irq_en_i) |=> irq_o); // R5

    AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_o)); // R7

    AST_ACT_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
        (act_o != '0) |-> $past(cmd_go_i)); // R7

    AST_CMD_GIVES_ACT: assert property (@(posedge clk) disable iff (rst)
        cmd_go_i |=> ($countones(act_o) == 1)); // R7

    AST_TOC_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
        (cmd_go_i && cmd_b == CMD_TOC && !stat_ld_i) |=> $stable(status_q[15:8])); // R6

endmodule

bind drv_stat_fmt drv_stat_fmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .export_i  (export_i),
    .irq_en_i  (irq_en_i),
    .irq_o     (irq_o),
    .cmd_go_i  (cmd_go_i),
    .stat_ld_i (stat_ld_i),
    .act_o     (act_o),
    .status_q  (stat_word),
    .pkt_win   (win_bytes[drv_stat_pkg::CSUM_IDX:drv_stat_pkg::WIN_BASE]),
    .ctrl_b    (win_bytes[drv_stat_pkg::CTRL_LO_IDX]),
    .cmd_b     (win_bytes[drv_stat_pkg::CMD_IDX])
);

// File: tb/drv_stat_fmt_tb.sv
module drv_stat_fmt_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [4:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        stat_ld = 1'b0;
    logic [15:0] stat_in = '0;
    logic        export_s = 1'b0;
    logic [15:0] min_in = '0, sec_in = '0, frm_in = '0;
    logic [7:0]  ext_in = '0;
    logic        irq_en = 1'b0;
    logic        irq;
    logic        cmd_go = 1'b0;
    logic [12:0] act;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R3 reset";

    drv_stat_fmt dut_i (
        .clk(clk), .rst(rst),
        .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .stat_ld_i(stat_ld), .stat_i(stat_in),
        .export_i(export_s), .min_i(min_in), .sec_i(sec_in), .frm_i(frm_in), .ext_i(ext_in),
        .irq_en_i(irq_en), .irq_o(irq),
        .cmd_go_i(cmd_go), .act_o(act)
    );

    // behavioural reference state
    logic [7:0]  mb [24];
    logic [7:0]  ob [24];
    logic [15:0] mst, ost;
    logic        mirq = 1'b0;
    logic [12:0] mact = '0;

    function automatic int code_bit(input logic [7:0] c);
        case (c)
            8'h00: return 0;
            8'h01: return 1;
            8'h03: return 3;
            8'h04: return 4;
            8'h06: return 5;
            8'h07: return 6;
            8'h08: return 7;
            8'h09: return 8;
            8'h0A: return 9;
            8'h0C: return 10;
            8'h0D: return 11;
            default: return 12;
        endcase
    endfunction

    function automatic string region(input int a);
        if (a == 13) return "R2";
        if (a == 3) return "R4";
        if (a >= 4 && a <= 12) return "R1";
        return "R9";
    endfunction

    always @(posedge clk) begin
        int s;
        logic [3:0] t;
        logic [7:0] e;
        if (rst) begin
            for (int i = 0; i < 24; i++) mb[i] = 8'h00;
            mb[13] = 8'h0F;
            mst = '0; mirq = 1'b0; mact = '0;
        end else begin
            for (int i = 0; i < 24; i++) ob[i] = mb[i];
            ost = mst;
            if (host_we && host_addr < 24) mb[host_addr] = host_wdata;
            if (stat_ld) mst = stat_in;
            mact = '0;
            if (cmd_go) begin
                if (ob[14] == 8'h02) begin
                    if (ob[17] <= 8'h05) begin mst[7:0] = ob[17]; mact[2] = 1'b1; end
                    else begin mst[7:0] = 8'h0F; mact[0] = 1'b1; end
                end else begin
                    mact[code_bit(ob[14])] = 1'b1;
                end
            end
            if (export_s) begin
                mb[4] = ost[15:8];   mb[5] = ost[7:0];
                mb[6] = min_in[15:8]; mb[7] = min_in[7:0];
                mb[8] = sec_in[15:8]; mb[9] = sec_in[7:0];
                mb[10] = frm_in[15:8]; mb[11] = frm_in[7:0];
                mb[12] = ext_in;
                s = 0;
                for (int k = 4; k <= 12; k++) s += int'(mb[k]);
                t = s[3:0];
                mb[13] = {4'h0, ~t};
                mb[3] = ob[3] & 8'h03;
            end
            mirq = export_s && irq_en;
        end
        #5;
        total++;
        if (irq !== mirq) begin
            bad++;
            $display("FAIL %s R5 irq_o got %0b exp %0b", tag, irq, mirq);
        end
        total++;
        if (act !== mact) begin
            bad++;
            $display("FAIL %s R7 act_o got %h exp %h", tag, act, mact);
        end
        e = (rd_addr < 24) ? mb[rd_addr] : 8'h00;
        total++;
        if (rd_data !== e) begin
            bad++;
            $display("FAIL %s %s rd[%0d] got %h exp %h", tag, region(int'(rd_addr)), rd_addr, rd_data, e);
        end
    end

    task automatic quiet();
        host_we = 1'b0; stat_ld = 1'b0; export_s = 1'b0; cmd_go = 1'b0;
    endtask

    task automatic sweep();
        for (int a = 0; a < 32; a++) begin
            @(negedge clk); quiet(); rd_addr = 5'(a);
        end
    endtask

    task automatic hw(input int a, input logic [7:0] d);
        @(negedge clk); quiet();
        host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
    endtask

    task automatic load_stat(input logic [15:0] v);
        @(negedge clk); quiet(); stat_ld = 1'b1; stat_in = v;
    endtask

    task automatic do_export(input logic [15:0] m, input logic [15:0] s,
                             input logic [15:0] f, input logic [7:0] x, input logic en);
        @(negedge clk); quiet();
        export_s = 1'b1; min_in = m; sec_in = s; frm_in = f; ext_in = x; irq_en = en;
    endtask

    task automatic do_cmd(input logic [7:0] code, input logic [7:0] sub);
        hw(14, code);
        hw(17, sub);
        @(negedge clk); quiet(); cmd_go = 1'b1;
        @(negedge clk); quiet();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R3 reset state";
        sweep();
        rst = 1'b0;
        sweep();

        tag = "R9 host window";
        hw(0, 8'hA5); hw(1, 8'h5A); hw(2, 8'hFF); hw(3, 8'hFE);
        hw(20, 8'h33); hw(23, 8'hC3); hw(26, 8'h77); hw(31, 8'h11);
        sweep();

        tag = "R1 R8 export layout";
        load_stat(16'h1234);
        do_export(16'h0159, 16'h2A3B, 16'h4C5D, 8'h6E, 1'b1);
        sweep();

        tag = "R5 irq disabled";
        do_export(16'h0001, 16'h0002, 16'h0003, 8'h04, 1'b0);
        sweep();

        tag = "R2 checksum wrap";
        load_stat(16'hFFFF);
        do_export(16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFF, 1'b1);
        sweep();

        tag = "R7 command decode";
        for (int c = 0; c < 16; c++) begin
            if (c != 2) do_cmd(8'(c), 8'h00);
        end
        do_cmd(8'h20, 8'h00);
        do_cmd(8'hFF, 8'h02);
        sweep();

        tag = "R6 toc sub-code";
        load_stat(16'hAB00);
        foreach (ob[j]) begin
            if (j < 9) begin
                do_cmd(8'h02, (j == 8) ? 8'h80 : 8'(j));
                do_export(16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0);
                sweep();
            end
        end

        tag = "R10 export beats host write";
        hw(3, 8'hF7);
        @(negedge clk); quiet();
        export_s = 1'b1; host_we = 1'b1; host_addr = 5'd7; host_wdata = 8'h99;
        @(negedge clk); quiet();
        export_s = 1'b1; host_we = 1'b1; host_addr = 5'd3; host_wdata = 8'hFF;
        @(negedge clk); quiet();
        export_s = 1'b1; host_we = 1'b1; host_addr = 5'd2; host_wdata = 8'h3C;
        sweep();

        tag = "R8 random exports";
        for (int n = 0; n < 30; n++) begin
            if (n % 3 == 0) load_stat(16'($urandom));
            if (n % 4 == 1) hw($urandom % 32, 8'($urandom));
            do_export(16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), 1'($urandom));
            @(negedge clk); quiet(); rd_addr = 5'(4 + (n % 10));
        end
        sweep();

        tag = "R3 reset again";
        @(negedge clk); quiet(); rst = 1'b1;
        @(negedge clk); quiet();
        @(negedge clk); rst = 1'b0;
        sweep();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule